// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block compares two IEEE-754 operands of the same precision and reduces the result to one condition bit. A select input chooses the precision. When it is 0, both operands are single precision and are taken from the low 32 bits of the 64-bit operand ports. When it is 1, both are double precision. The two operands are ordered into one of four outcomes: less, equal, greater or unordered. A 3-bit predicate code then maps that outcome to the condition bit. The comparison is quiet, so a quiet NaN makes the outcome unordered without raising an exception. A signalling NaN also gives unordered and raises an invalid flag.

Alongside the condition bit, the block returns an updated copy of a 32-bit status word. Bits 27 to 0 are passed through unchanged. The top nibble is cleared, and bit 29 then carries the condition bit. Operands, predicate code and status word are captured on an input strobe. Result, status and flag are registered and appear one cycle later, marked by an output valid pulse. They hold their values until the next strobe.

Top module: `fcmp_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high for exactly one cycle, one clock cycle after that edge, and the new `cmp_result`, `status_out` and `invalid_flag` are present with it. Without a strobe, all three outputs keep their values.
- R2: With outcome LT, EQ, GT or UN, the predicate code sets `cmp_result` as follows. Code 0 is never true. Code 1 is true for UN. Code 2 is true for EQ. Code 3 is true for UN or EQ. Code 4 is true for LT. Code 5 is true for UN or LT. Code 6 is true for LT or EQ. Code 7 is true for every outcome except GT.
- R3: Only `cond_code[2:0]` selects the predicate, and `cond_code[3]` has no effect.
- R4: `status_out` equals `status_in[27:0]` in bits 27..0. Bits 31, 30 and 28 are 0, and bit 29 equals `cmp_result`.
- R5: If either operand is a quiet NaN (exponent all ones, mantissa MSB set), the outcome is UN and `invalid_flag` is 0, unless the other operand is a signalling NaN.
- R6: If either operand is a signalling NaN (exponent all ones, mantissa MSB clear, mantissa nonzero), `invalid_flag` is 1 and the outcome is UN.
- R7: +0 and -0 compare EQ, in either order and at both precisions.
- R8: With `dbl_sel`=0, only bits 31..0 of each operand are used: sign at bit 31, 8-bit exponent at 30..23, 23-bit mantissa. With `dbl_sel`=1, all 64 bits are used: sign at bit 63, 11-bit exponent at 62..52, 52-bit mantissa.
- R9: Non-NaN operands are ordered by numeric value, including negative values and infinities.
- R10: While reset is applied, `out_valid`, `cmp_result`, `status_out` and `invalid_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for operands, code and status |
| dbl_sel | input | 1 | 0 single precision, 1 double precision |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_code | input | 4 | Predicate code, low 3 bits used |
| status_in | input | 32 | Status word to update |
| out_valid | output | 1 | Result valid pulse |
| cmp_result | output | 1 | Predicate result |
| status_out | output | 32 | Updated status word |
| invalid_flag | output | 1 | Signalling NaN seen |

## Verification
The hardest case to reach is an operand pair whose outcome depends on the precision select. The stimulus uses a pair whose low words decode in single precision as +0 and a tiny denormal, while the full 64-bit words decode as 2.0 and a value just above 1.0. Checking the same pair under both select values shows that the wrong field layout cannot go unnoticed. Each predicate code is also applied to one operand pair for each of the four outcomes. This fills the full 8-by-4 truth table, with NaN payloads of both quiet and signalling kind.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int OP_W      = 64;
  localparam int MAG_W     = OP_W - 1;
  localparam int SP_EXP_W  = 8;
  localparam int SP_MAN_W  = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_MAN_W  = 52;
  localparam int PRED_W    = 3;
  localparam int STAT_W    = 32;
  localparam int CBIT_POS  = 29;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2,
    ORD_UN = 2'd3
  } cmp_order_e;

  typedef struct packed {
    logic             sign;
    logic             is_zero;
    logic             is_nan;
    logic             is_snan;
    logic [MAG_W-1:0] mag;
  } fp_class_t;
endpackage

// File: rtl/fcmp_rst_sync.sv
module fcmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fcmp_field_decode.sv
module fcmp_field_decode
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] bits_i,
  output fp_class_t            cls_o
);
  localparam int BODY_W = EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             exp_zero;
  logic             man_nz;

  always_comb begin
    exp_f    = bits_i[BODY_W-1:MAN_W];
    man_f    = bits_i[MAN_W-1:0];
    exp_ones = &exp_f;
    exp_zero = ~|exp_f;
    man_nz   = |man_f;
    cls_o         = '0;
    cls_o.sign    = bits_i[BODY_W];
    cls_o.is_nan  = exp_ones & man_nz;
    cls_o.is_snan = exp_ones & man_nz & ~man_f[MAN_W-1];
    cls_o.is_zero = exp_zero & ~man_nz;
    cls_o.mag[BODY_W-1:0] = bits_i[BODY_W-1:0];
  end
endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            dbl_i,
  output fp_class_t       cls_o
);
  fp_class_t fmt_cls [2];

  for (genvar g = 0; g < 2; g++) begin : g_fmt
    localparam int EW = (g == 0) ? SP_EXP_W : DP_EXP_W;
    localparam int MW = (g == 0) ? SP_MAN_W : DP_MAN_W;
    fcmp_field_decode #(
      .EXP_W (EW),
      .MAN_W (MW)
    ) u_dec (
      .bits_i (op_i[EW+MW:0]),
      .cls_o  (fmt_cls[g])
    );
  end

  assign cls_o = dbl_i ? fmt_cls[1] : fmt_cls[0];
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
(
  input  fp_class_t  a_i,
  input  fp_class_t  b_i,
  output cmp_order_e order_o
);
  logic mag_lt;
  logic mag_eq;

  always_comb begin
    mag_lt = a_i.mag < b_i.mag;
    mag_eq = a_i.mag == b_i.mag;
    if (a_i.is_nan || b_i.is_nan) begin
      order_o = ORD_UN;
    end else if (a_i.is_zero && b_i.is_zero) begin
      order_o = ORD_EQ;
    end else if (a_i.sign != b_i.sign) begin
      order_o = a_i.sign ? ORD_LT : ORD_GT;
    end else if (mag_eq) begin
      order_o = ORD_EQ;
    end else if (a_i.sign) begin
      order_o = mag_lt ? ORD_GT : ORD_LT;
    end else begin
      order_o = mag_lt ? ORD_LT : ORD_GT;
    end
  end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
  import fcmp_pkg::*;
(
  input  logic [PRED_W-1:0] code_i,
  input  cmp_order_e        order_i,
  output logic              hit_o
);
  // code bit 0 admits unordered, bit 1 admits equal, bit 2 admits less
  logic [PRED_W-1:0] admit;

  always_comb begin
    admit[0] = order_i == ORD_UN;
    admit[1] = order_i == ORD_EQ;
    admit[2] = order_i == ORD_LT;
    hit_o    = |(code_i & admit);
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              dbl_sel,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [COND_W-1:0] cond_code,
  input  logic [STAT_W-1:0] status_in,
  output logic              out_valid,
  output logic              cmp_result,
  output logic [STAT_W-1:0] status_out,
  output logic              invalid_flag
);
  localparam int KEEP_W = STAT_W - 4;

  logic rst_sync_n;

  fcmp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic unused_bits;
  assign unused_bits = ^{cond_code[COND_W-1:PRED_W], status_in[STAT_W-1:KEEP_W]};

  // capture stage
  logic              s1_vld_q,  s1_vld_d;
  logic              s1_dbl_q,  s1_dbl_d;
  logic [OP_W-1:0]   s1_a_q,    s1_a_d;
  logic [OP_W-1:0]   s1_b_q,    s1_b_d;
  logic [PRED_W-1:0] s1_cond_q, s1_cond_d;
  logic [KEEP_W-1:0] s1_stat_q, s1_stat_d;

  always_comb begin
    s1_vld_d  = in_valid;
    s1_dbl_d  = s1_dbl_q;
    s1_a_d    = s1_a_q;
    s1_b_d    = s1_b_q;
    s1_cond_d = s1_cond_q;
    s1_stat_d = s1_stat_q;
    if (in_valid) begin
      s1_dbl_d  = dbl_sel;
      s1_a_d    = op_a;
      s1_b_d    = op_b;
      s1_cond_d = cond_code[PRED_W-1:0];
      s1_stat_d = status_in[KEEP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld_q  <= 1'b0;
      s1_dbl_q  <= 1'b0;
      s1_a_q    <= '0;
      s1_b_q    <= '0;
      s1_cond_q <= '0;
      s1_stat_q <= '0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      s1_dbl_q  <= s1_dbl_d;
      s1_a_q    <= s1_a_d;
      s1_b_q    <= s1_b_d;
      s1_cond_q <= s1_cond_d;
      s1_stat_q <= s1_stat_d;
    end
  end

  // compare datapath
  fp_class_t  cls_a, cls_b;
  cmp_order_e s1_order;
  logic       s1_hit;
  logic       s1_invalid;

  fcmp_classify u_cls_a (.op_i(s1_a_q), .dbl_i(s1_dbl_q), .cls_o(cls_a));
  fcmp_classify u_cls_b (.op_i(s1_b_q), .dbl_i(s1_dbl_q), .cls_o(cls_b));

  fcmp_order u_order (.a_i(cls_a), .b_i(cls_b), .order_o(s1_order));

  fcmp_predicate u_pred (.code_i(s1_cond_q), .order_i(s1_order), .hit_o(s1_hit));

  assign s1_invalid = cls_a.is_snan | cls_b.is_snan;

  // output stage
  logic              ov_d, res_d, inv_d;
  logic [STAT_W-1:0] stat_d;

  always_comb begin
    ov_d   = s1_vld_q;
    res_d  = cmp_result;
    inv_d  = invalid_flag;
    stat_d = status_out;
    if (s1_vld_q) begin
      res_d  = s1_hit;
      inv_d  = s1_invalid;
      stat_d = {4'b0000, s1_stat_q};
      stat_d[CBIT_POS] = s1_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid    <= 1'b0;
      cmp_result   <= 1'b0;
      invalid_flag <= 1'b0;
      status_out   <= '0;
    end else begin
      out_valid    <= ov_d;
      cmp_result   <= res_d;
      invalid_flag <= inv_d;
      status_out   <= stat_d;
    end
  end

  // assertions
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> ##1 out_valid);

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !s1_vld_q |=> ($stable(cmp_result) && $stable(status_out) && $stable(invalid_flag)));

  a_r4_status_top: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (status_out[31:30] == 2'b00 && !status_out[28]
                   && status_out[CBIT_POS] == cmp_result));

  a_r2_code_false: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_vld_q && s1_cond_q == 3'd0) |=> !cmp_result);

  a_r6_snan_unordered: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_vld_q && s1_invalid) |-> s1_order == ORD_UN);

  a_r7_zero_equal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_vld_q && cls_a.is_zero && cls_b.is_zero) |-> s1_order == ORD_EQ);

  a_r5_qnan_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_vld_q && (cls_a.is_nan || cls_b.is_nan) && !s1_invalid) |=> !invalid_flag);
endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        dbl_sel = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [3:0]  cond_code = '0;
  logic [31:0] status_in = '0;
  logic        out_valid;
  logic        cmp_result;
  logic [31:0] status_out;
  logic        invalid_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  fcmp_unit u_fcmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel),
    .op_a(op_a), .op_b(op_b), .cond_code(cond_code), .status_in(status_in),
    .out_valid(out_valid), .cmp_result(cmp_result), .status_out(status_out),
    .invalid_flag(invalid_flag)
  );

  // outcome codes used in the bench: 0 less, 1 equal, 2 greater, 3 unordered
  localparam int O_LT = 0, O_EQ = 1, O_GT = 2, O_UN = 3;

  localparam logic [31:0] S_ONE = 32'h3F80_0000, S_TWO = 32'h4000_0000;
  localparam logic [31:0] S_MONE = 32'hBF80_0000, S_MTWO = 32'hC000_0000;
  localparam logic [31:0] S_PZ = 32'h0000_0000, S_NZ = 32'h8000_0000;
  localparam logic [31:0] S_QNAN = 32'h7FC0_0000, S_SNAN = 32'h7F80_0001;
  localparam logic [31:0] S_PINF = 32'h7F80_0000, S_NINF = 32'hFF80_0000;
  localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_TWO = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D_MTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000, D_SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] D_NZ = 64'h8000_0000_0000_0000;

  function automatic bit ref_pred(input int code, input int o);
    case (code)
      0: return 1'b0;
      1: return o == O_UN;
      2: return o == O_EQ;
      3: return (o == O_UN) || (o == O_EQ);
      4: return o == O_LT;
      5: return (o == O_UN) || (o == O_LT);
      6: return (o == O_LT) || (o == O_EQ);
      default: return o != O_GT;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one compare and check every output at the cycle it appears
  task automatic apply(input bit dbl, input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] code, input logic [31:0] st,
                       input int outcome, input bit exp_inv, input string req);
    bit          exp_res;
    logic [31:0] exp_st;
    exp_res = ref_pred(int'(code[2:0]), outcome);
    exp_st  = {2'b00, exp_res, 1'b0, st[27:0]};
    @(negedge clk);
    in_valid = 1'b1; dbl_sel = dbl; op_a = a; op_b = b; cond_code = code; status_in = st;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, {req, " R1 out_valid"}, 64'(out_valid), 64'd1);
    check(cmp_result == exp_res, {req, " result"}, 64'(cmp_result), 64'(exp_res));
    check(status_out == exp_st, {req, " R4 status"}, 64'(status_out), 64'(exp_st));
    check(invalid_flag == exp_inv, {req, " invalid"}, 64'(invalid_flag), 64'(exp_inv));
  endtask

  task automatic t_reset;
    check(out_valid == 0 && cmp_result == 0 && status_out == 0 && invalid_flag == 0,
          "R10 reset outputs", {out_valid, cmp_result, invalid_flag, status_out}, 64'd0);
  endtask

  task automatic t_truth_table;
    for (int c = 0; c < 8; c++) begin
      apply(0, {32'h0, S_ONE}, {32'h0, S_TWO}, 4'(c), 32'h0A5A_5A5A, O_LT, 0, "R2 LT");
      apply(0, {32'h0, S_ONE}, {32'h0, S_ONE}, 4'(c), 32'hFFFF_FFFF, O_EQ, 0, "R2 EQ");
      apply(0, {32'h0, S_TWO}, {32'h0, S_ONE}, 4'(c), 32'h1234_5678, O_GT, 0, "R2 GT");
      apply(0, {32'h0, S_ONE}, {32'h0, S_QNAN}, 4'(c), 32'h0000_0000, O_UN, 0, "R2 UN");
    end
  endtask

  task automatic t_code_high_bit;
    apply(0, {32'h0, S_ONE}, {32'h0, S_ONE}, 4'b1010, 32'hFFFF_FFFF, O_EQ, 0, "R3 hi bit code 2");
    apply(0, {32'h0, S_ONE}, {32'h0, S_ONE}, 4'b1000, 32'hFFFF_FFFF, O_EQ, 0, "R3 hi bit code 0");
  endtask

  task automatic t_nans;
    apply(0, {32'h0, S_QNAN}, {32'h0, S_QNAN}, 4'd1, 32'h0, O_UN, 0, "R5 qnan sp");
    apply(1, D_QNAN, D_ONE, 4'd7, 32'h0, O_UN, 0, "R5 qnan dp");
    apply(0, {32'h0, S_SNAN}, {32'h0, S_ONE}, 4'd1, 32'h0, O_UN, 1, "R6 snan sp a");
    apply(1, D_ONE, D_SNAN, 4'd2, 32'h0, O_UN, 1, "R6 snan dp b");
    apply(0, {32'h0, S_QNAN}, {32'h0, S_SNAN}, 4'd3, 32'h0, O_UN, 1, "R6 snan with qnan");
  endtask

  task automatic t_zeros;
    apply(0, {32'h0, S_PZ}, {32'h0, S_NZ}, 4'd2, 32'h0, O_EQ, 0, "R7 +0 -0 sp");
    apply(0, {32'h0, S_NZ}, {32'h0, S_PZ}, 4'd4, 32'h0, O_EQ, 0, "R7 -0 +0 sp");
    apply(1, D_NZ, 64'h0, 4'd6, 32'h0, O_EQ, 0, "R7 -0 +0 dp");
  endtask

  task automatic t_ordering;
    apply(0, {32'h0, S_MONE}, {32'h0, S_ONE}, 4'd4, 32'h0, O_LT, 0, "R9 neg vs pos");
    apply(0, {32'h0, S_MTWO}, {32'h0, S_MONE}, 4'd4, 32'h0, O_LT, 0, "R9 two negatives");
    apply(0, {32'h0, S_MONE}, {32'h0, S_MTWO}, 4'd6, 32'h0, O_GT, 0, "R9 neg reversed");
    apply(0, {32'h0, S_NINF}, {32'h0, S_MTWO}, 4'd4, 32'h0, O_LT, 0, "R9 -inf");
    apply(0, {32'h0, S_PINF}, {32'h0, S_TWO}, 4'd7, 32'h0, O_GT, 0, "R9 +inf");
    apply(0, {32'h0, S_PINF}, {32'h0, S_PINF}, 4'd2, 32'h0, O_EQ, 0, "R9 inf equal");
    apply(1, D_MTWO, D_TWO, 4'd5, 32'h0, O_LT, 0, "R9 dp signs");
  endtask

  task automatic t_precision;
    apply(0, {32'hFFFF_FFFF, S_ONE}, {32'h0, S_TWO}, 4'd4, 32'h0, O_LT, 0, "R8 sp ignores upper");
    apply(1, D_TWO, 64'h3FF0_0000_0000_0001, 4'd4, 32'h0, O_GT, 0, "R8 dp layout");
    apply(0, D_TWO, 64'h3FF0_0000_0000_0001, 4'd4, 32'h0, O_LT, 0, "R8 sp layout");
  endtask

  task automatic t_hold;
    logic [31:0] st_before;
    logic        res_before;
    apply(0, {32'h0, S_ONE}, {32'h0, S_ONE}, 4'd2, 32'h0555_0001, O_EQ, 0, "R1 setup");
    st_before  = status_out;
    res_before = cmp_result;
    @(negedge clk);
    op_a = {32'h0, S_TWO}; cond_code = 4'd0; status_in = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 0, "R1 pulse single", 64'(out_valid), 64'd0);
    check(status_out == st_before && cmp_result == res_before, "R1 hold without strobe",
          {status_out, 31'h0, cmp_result}, {st_before, 31'h0, res_before});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_truth_table();
    t_code_high_bit();
    t_nans();
    t_zeros();
    t_ordering();
    t_precision();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule